// File: doc/BRIEF.md
# Variable-Length Instruction Word Decoder

This block walks a program held in a 16-bit word memory. It starts at a program counter given with a start pulse. It reads the opcode word at that address and looks up how many operand words follow, which may be none, one, two or three. It then reads those operand words one after another. Each operand word is classified by its value range. It is either a 15-bit literal or a reference to one of eight registers.

When the last word of an instruction has been read, the decoder presents the instruction and a valid strobe. The instruction is given as the opcode, the operand count, a kind bit per operand slot and a value per slot. The next program counter is presented with it. The output is held until the consumer accepts it with a ready handshake. The decoder then fetches the following instruction at that next program counter.

An opcode word outside the defined set stops decoding, and so does an operand word outside both ranges. The block raises a sticky fault and reports the address of the word that caused it. The fault is cleared only by reset.

Top module: `instr_word_decoder`

## Requirements
- R1: After reset the block is idle: no memory request, no valid strobe, no fault.
- R2: An operand word from 0 to 32767 is a literal: its kind bit is 0 and its slot value is the word itself.
- R3: An operand word from 32768 to 32775 is a register reference: its kind bit is 1 and its slot value is the word minus 32768 (0 to 7).
- R4: An operand word of 32776 or more raises the fault, and the fault address output gives that word's address.
- R5: An opcode word of 22 or more raises the fault, and this includes every word with bit 15 set. The fault address output gives the opcode's address.
- R6: The operand count follows the opcode. Opcodes 0, 18 and 21 take none. Opcodes 2, 3, 6, 17, 19 and 20 take one. Opcodes 1, 7, 8, 14, 15 and 16 take two. Opcodes 4, 5 and 9 to 13 take three.
- R7: The next program counter is the opcode address plus one plus the operand count. After a handshake the next memory request goes to that address.
- R8: While valid is high and ready is low, every decoded output holds its value.
- R9: Once raised, the fault stays high with a stable address. No memory request or valid strobe follows until reset.
- R10: Memory is read one word at a time. A request in one cycle is followed by a cycle without a request, and the read data is sampled in that cycle.
- R11: Operand slots at or above the operand count present kind 0 and value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin decoding at start_pc_i (taken only when idle) |
| start_pc_i | input | 16 | First opcode address |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Read data, valid the cycle after the request |
| dec_valid_o | output | 1 | Decoded instruction available |
| dec_ready_i | input | 1 | Consumer accepts the decoded instruction |
| dec_opcode_o | output | 5 | Opcode |
| dec_nops_o | output | 2 | Operand count |
| dec_kind_o | output | 3 | Per slot: 1 register, 0 literal (bit 0 is the first operand) |
| dec_val_o | output | 45 | Per slot 15-bit value, slot 0 in bits 14:0 |
| next_pc_o | output | 16 | Address following the decoded instruction |
| fault_o | output | 1 | Sticky illegal-word fault |
| fault_addr_o | output | 16 | Address of the word that caused the fault |

## Verification
The corner that is hardest to reach from the ports is the sequence that ends in a fault. The good instructions before it must all be delivered, and then nothing more may appear. Stimulus gets there by loading one program that uses all 22 opcodes, with operands that mix literals and registers at both range edges, and by ending it with an illegal opcode. The consumer's ready line follows an irregular pattern throughout, so backpressure lands on instructions of every length. Two further short programs follow a reset each. One faults on an operand word one past the last register, and one faults on an opcode word with its top bit set.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int OPC_W       = 5;
  localparam int NUM_OPCODES = 22;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_CAP, ST_SHOW, ST_FAULT
  } dec_state_e;

  function automatic logic [1:0] arg_count(input logic [OPC_W-1:0] opc);
    case (opc)
      5'd2, 5'd3, 5'd6, 5'd17, 5'd19, 5'd20:         return 2'd1;
      5'd1, 5'd7, 5'd8, 5'd14, 5'd15, 5'd16:         return 2'd2;
      5'd4, 5'd5, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13:  return 2'd3;
      default:                                       return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/ivd_word_class.sv
module ivd_word_class #(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 8
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              is_reg_o,
  output logic              bad_o,
  output logic [WORD_W-2:0] val_o
);
  localparam logic [WORD_W:0] LIT_LIM = (WORD_W+1)'(1) << (WORD_W-1);
  localparam logic [WORD_W:0] REG_END = LIT_LIM + (WORD_W+1)'(NUM_REGS);

  logic [WORD_W:0] ext;
  logic            is_lit;

  assign ext      = {1'b0, word_i};
  assign is_lit   = ext < LIT_LIM;
  assign is_reg_o = !is_lit && (ext < REG_END);
  assign bad_o    = !is_lit && !is_reg_o;
  // register index is the word minus the literal limit: just the low bits
  assign val_o    = bad_o ? '0 : word_i[WORD_W-2:0];
endmodule

// File: rtl/ivd_op_table.sv
module ivd_op_table
  import ivd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              legal_o,
  output logic [OPC_W-1:0]  opc_o,
  output logic [1:0]        nargs_o
);
  assign legal_o = word_i < WORD_W'(NUM_OPCODES);
  assign opc_o   = word_i[OPC_W-1:0];
  assign nargs_o = legal_o ? arg_count(opc_o) : 2'd0;
endmodule

// File: rtl/ivd_operand_slots.sv
module ivd_operand_slots #(
  parameter int MAX_OPS = 3,
  parameter int VAL_W   = 15,
  parameter int IDX_W   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic                     wr_kind_i,
  input  logic [VAL_W-1:0]         wr_val_i,
  output logic [MAX_OPS-1:0]       kind_o,
  output logic [MAX_OPS*VAL_W-1:0] val_o
);
  for (genvar s = 0; s < MAX_OPS; s++) begin : g_slot
    logic             kind_q;
    logic [VAL_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        kind_q <= 1'b0;
        val_q  <= '0;
      end else if (clr_i) begin
        kind_q <= 1'b0;
        val_q  <= '0;
      end else if (wr_i && wr_idx_i == IDX_W'(s)) begin
        kind_q <= wr_kind_i;
        val_q  <= wr_val_i;
      end
    end
    assign kind_o[s]                 = kind_q;
    assign val_o[s*VAL_W +: VAL_W]   = val_q;
  end
endmodule

// File: rtl/instr_word_decoder.sv
module instr_word_decoder
  import ivd_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int MAX_OPS  = 3,
  localparam int VAL_W   = WORD_W - 1,
  localparam int IDX_W   = $clog2(MAX_OPS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [WORD_W-1:0]        start_pc_i,
  output logic                     mem_req_o,
  output logic [WORD_W-1:0]        mem_addr_o,
  input  logic [WORD_W-1:0]        mem_rdata_i,
  output logic                     dec_valid_o,
  input  logic                     dec_ready_i,
  output logic [OPC_W-1:0]         dec_opcode_o,
  output logic [IDX_W-1:0]         dec_nops_o,
  output logic [MAX_OPS-1:0]       dec_kind_o,
  output logic [MAX_OPS*VAL_W-1:0] dec_val_o,
  output logic [WORD_W-1:0]        next_pc_o,
  output logic                     fault_o,
  output logic [WORD_W-1:0]        fault_addr_o
);
  dec_state_e        state_q, state_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [OPC_W-1:0]  opc_q, opc_d;
  logic [IDX_W-1:0]  nops_q, nops_d;
  logic [WORD_W-1:0] faddr_q, faddr_d;
  logic [WORD_W-1:0] cur_addr;

  logic              op_legal;
  logic [OPC_W-1:0]  op_code;
  logic [1:0]        op_nargs;
  logic              w_is_reg, w_bad;
  logic [VAL_W-1:0]  w_val;
  logic              slot_clr, slot_wr;
  logic [IDX_W-1:0]  slot_idx;

  ivd_op_table #(.WORD_W(WORD_W)) u_table (
    .word_i (mem_rdata_i),
    .legal_o(op_legal),
    .opc_o  (op_code),
    .nargs_o(op_nargs)
  );

  ivd_word_class #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_class (
    .word_i  (mem_rdata_i),
    .is_reg_o(w_is_reg),
    .bad_o   (w_bad),
    .val_o   (w_val)
  );

  ivd_operand_slots #(.MAX_OPS(MAX_OPS), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_slots (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (slot_clr),
    .wr_i     (slot_wr),
    .wr_idx_i (slot_idx),
    .wr_kind_i(w_is_reg),
    .wr_val_i (w_val),
    .kind_o   (dec_kind_o),
    .val_o    (dec_val_o)
  );

  assign cur_addr  = base_q + WORD_W'(idx_q);
  assign next_pc_o = base_q + WORD_W'(1) + WORD_W'(nops_q);
  assign slot_idx  = idx_q - IDX_W'(1);

  always_comb begin
    state_d  = state_q;
    base_d   = base_q;
    idx_d    = idx_q;
    opc_d    = opc_q;
    nops_d   = nops_q;
    faddr_d  = faddr_q;
    slot_clr = 1'b0;
    slot_wr  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        base_d  = start_pc_i;
        idx_d   = '0;
        state_d = ST_REQ;
      end
      ST_REQ: state_d = ST_CAP;
      ST_CAP: begin
        if (idx_q == '0) begin
          if (!op_legal) begin
            faddr_d = cur_addr;
            state_d = ST_FAULT;
          end else begin
            opc_d    = op_code;
            nops_d   = IDX_W'(op_nargs);
            slot_clr = 1'b1;
            if (op_nargs == 2'd0) state_d = ST_SHOW;
            else begin
              idx_d   = IDX_W'(1);
              state_d = ST_REQ;
            end
          end
        end else if (w_bad) begin
          faddr_d = cur_addr;
          state_d = ST_FAULT;
        end else begin
          slot_wr = 1'b1;
          if (idx_q == nops_q) state_d = ST_SHOW;
          else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_REQ;
          end
        end
      end
      ST_SHOW: if (dec_ready_i) begin
        base_d  = next_pc_o;
        idx_d   = '0;
        state_d = ST_REQ;
      end
      ST_FAULT: state_d = ST_FAULT;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      opc_q   <= '0;
      nops_q  <= '0;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      idx_q   <= idx_d;
      opc_q   <= opc_d;
      nops_q  <= nops_d;
      faddr_q <= faddr_d;
    end
  end

  assign mem_req_o    = state_q == ST_REQ;
  assign mem_addr_o   = cur_addr;
  assign dec_valid_o  = state_q == ST_SHOW;
  assign dec_opcode_o = opc_q;
  assign dec_nops_o   = nops_q;
  assign fault_o      = state_q == ST_FAULT;
  assign fault_addr_o = faddr_q;
endmodule

// File: rtl/ivd_chk.sv
module ivd_chk #(
  parameter int WORD_W  = 16,
  parameter int MAX_OPS = 3,
  parameter int OPC_W   = 5,
  parameter int IDX_W   = 2,
  parameter int VAL_W   = 15
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     mem_req_o,
  input logic [WORD_W-1:0]        mem_addr_o,
  input logic                     dec_valid_o,
  input logic                     dec_ready_i,
  input logic [OPC_W-1:0]         dec_opcode_o,
  input logic [IDX_W-1:0]         dec_nops_o,
  input logic [MAX_OPS-1:0]       dec_kind_o,
  input logic [MAX_OPS*VAL_W-1:0] dec_val_o,
  input logic [WORD_W-1:0]        next_pc_o,
  input logic                     fault_o,
  input logic [WORD_W-1:0]        fault_addr_o
);
  // R10
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R8
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !dec_ready_i |=> dec_valid_o && $stable(dec_opcode_o) && $stable(dec_nops_o)
      && $stable(dec_kind_o) && $stable(dec_val_o) && $stable(next_pc_o));

  // R7
  next_fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_ready_i |=> mem_req_o && mem_addr_o == $past(next_pc_o));

  // R9
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o && $stable(fault_addr_o) && !mem_req_o && !dec_valid_o);

  // R11
  unused_slot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (dec_kind_o >> dec_nops_o) == '0);

  // R1
  valid_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_valid_o && (fault_o || mem_req_o)));
endmodule

bind instr_word_decoder ivd_chk #(
  .WORD_W(WORD_W), .MAX_OPS(MAX_OPS), .OPC_W(ivd_pkg::OPC_W), .IDX_W(IDX_W), .VAL_W(VAL_W)
) u_ivd_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .dec_valid_o (dec_valid_o),
  .dec_ready_i (dec_ready_i),
  .dec_opcode_o(dec_opcode_o),
  .dec_nops_o  (dec_nops_o),
  .dec_kind_o  (dec_kind_o),
  .dec_val_o   (dec_val_o),
  .next_pc_o   (next_pc_o),
  .fault_o     (fault_o),
  .fault_addr_o(fault_addr_o)
);

// File: tb/tb_instr_word_decoder.sv
module tb_instr_word_decoder;
  typedef struct {
    int unsigned opc;
    int unsigned n;
    logic [2:0]  kind;
    logic [44:0] vals;
    logic [15:0] npc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_pc = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [4:0]  dec_opcode;
  logic [1:0]  dec_nops;
  logic [2:0]  dec_kind;
  logic [44:0] dec_val;
  logic [15:0] next_pc;
  logic        fault;
  logic [15:0] fault_addr;

  logic [15:0] mem [0:255];
  exp_t        q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  instr_word_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_pc_i(start_pc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .dec_valid_o(dec_valid), .dec_ready_i(dec_ready), .dec_opcode_o(dec_opcode),
    .dec_nops_o(dec_nops), .dec_kind_o(dec_kind), .dec_val_o(dec_val),
    .next_pc_o(next_pc), .fault_o(fault), .fault_addr_o(fault_addr)
  );

  always_ff @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[7:0]];

  function automatic int unsigned n_args(input int unsigned opc);
    if (opc == 0 || opc == 18 || opc == 21) return 0;
    if (opc inside {2, 3, 6, 17, 19, 20}) return 1;
    if (opc inside {1, 7, 8, 14, 15, 16}) return 2;
    return 3;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: write one instruction into memory and queue its expected decode
  task automatic put_instr(inout int unsigned a, input int unsigned opc,
                           input int unsigned w0, input int unsigned w1, input int unsigned w2);
    exp_t e;
    int unsigned w[3];
    w = '{w0, w1, w2};
    e.opc = opc; e.n = n_args(opc); e.kind = '0; e.vals = '0;
    mem[a[7:0]] = 16'(opc);
    for (int k = 0; k < 3; k++) begin
      if (k < int'(e.n)) begin
        mem[8'(a + 1 + k)] = 16'(w[k]);
        if (w[k] >= 32768) begin e.kind[k] = 1'b1; e.vals[k*15 +: 15] = 15'(w[k] - 32768); end
        else e.vals[k*15 +: 15] = 15'(w[k]);
      end
    end
    a = a + 1 + e.n;
    e.npc = 16'(a);
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && dec_valid && dec_ready) begin
      if (q.size() == 0) check(1'b0, "R9", "unexpected decode", 64'(dec_opcode), 64'hFFFF);
      else begin
        exp_t e;
        e = q.pop_front();
        check(dec_opcode == 5'(e.opc) && dec_nops == 2'(e.n), "R6", "opcode/count",
              {dec_opcode, dec_nops}, {5'(e.opc), 2'(e.n)});
        check(dec_kind == e.kind && dec_val == e.vals, "R2 R3 R11", "operands",
              {dec_kind, dec_val}, {e.kind, e.vals});
        check(next_pc == e.npc, "R7", "next pc", 64'(next_pc), 64'(e.npc));
      end
    end
  end

  // irregular ready pattern
  initial begin
    int unsigned lf = 32'h1d;
    forever begin
      @(posedge clk); #1;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      dec_ready = (lf[2:0] != 3'd0) && (lf[4:3] != 2'd1);
    end
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc == 100000) begin
        check(1'b0, "WATCHDOG", "timeout", 64'(cyc), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_from(input int unsigned pc);
    @(posedge clk); #1 start = 1'b1; start_pc = 16'(pc);
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic expect_fault(input int unsigned addr, input string req);
    int t = 0;
    while (!fault && t < 3000) begin @(negedge clk); t++; end
    check(fault == 1'b1, req, "fault raised", 64'(fault), 1);
    check(fault_addr == 16'(addr), req, "fault address", 64'(fault_addr), 64'(addr));
    check(q.size() == 0, "R7", "pending decodes at fault", 64'(q.size()), 0);
  endtask

  task automatic check_silent_after_fault();
    bit quiet = 1'b1;
    logic [15:0] fa;
    fa = fault_addr;
    repeat (20) begin
      @(negedge clk);
      if (mem_req || dec_valid || !fault || fault_addr != fa) quiet = 1'b0;
    end
    check(quiet, "R9", "quiet after fault", 64'(quiet), 1);
  endtask

  initial begin
    int unsigned a;
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    do_reset();
    @(negedge clk);
    // R1
    check(!mem_req && !dec_valid && !fault, "R1", "reset state",
          {mem_req, dec_valid, fault}, 0);

    // program 1: every opcode, mixed operands, ends on opcode 22
    a = 10;
    for (int unsigned op = 0; op < 22; op++) begin
      int unsigned w[3];
      for (int k = 0; k < 3; k++)
        w[k] = ((op + k) % 2 == 1) ? 32768 + ((op + k) % 8) : op * 100 + k;
      put_instr(a, op, w[0], w[1], w[2]);
    end
    put_instr(a, 7, 32775, 32767, 0);   // R3 / R2 range edges
    put_instr(a, 9, 0, 32768, 32767);
    mem[a[7:0]] = 16'd22;
    run_from(10);
    expect_fault(a, "R5");
    check_silent_after_fault();

    // program 2: operand word just past the last register
    do_reset();
    q.delete();
    a = 64;
    put_instr(a, 1, 32770, 5, 0);
    mem[a[7:0]] = 16'd9; mem[8'(a + 1)] = 16'd32768; mem[8'(a + 2)] = 16'd32776;
    run_from(64);
    expect_fault(a + 2, "R4");
    check_silent_after_fault();

    // program 3: opcode word with top bit set
    do_reset();
    q.delete();
    mem[200] = 16'd32768;
    run_from(200);
    expect_fault(200, "R5");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule